// File: doc/BRIEF.md
# DDR Read Burst Output Scheduler with Precharge Truncation

This block models the read output path of a double-data-rate memory device. It runs on a clock at twice the memory clock rate, so one tick is half a memory clock. It takes decoded commands with a bank address and a column address. A Read starts an eight-beat burst after the programmed CAS latency, with one beat per tick. The data strobe is driven low for one memory clock before the first beat, toggles once per beat, and is released after the last beat.

A Precharge to the bank of an in-flight read cuts that burst short. The outputs turn off exactly one CAS latency after the Precharge, so the number of beats delivered equals the distance in ticks between the Read and the Precharge, capped at eight. The half-cycle latency setting of 2.5 memory clocks works the same way for both the read and the truncation, because all latencies are counted in ticks.

Top module: `ddr_rd_trunc`

## Requirements
- R1: `cmd` is decoded as 2'b01 Read and 2'b10 Precharge. Codes 2'b00 and 2'b11 are no-operations and have no effect on a burst in progress.
- R2: `cl_mode` selects the latency L in ticks: 0 gives 4, 1 gives 5, 2 and 3 give 6. A Read sampled at rising edge E shows its first beat on the outputs right after edge E+L.
- R3: A burst that is not interrupted holds `dq_valid` high for exactly 8 consecutive ticks.
- R4: Beat k (0..7) carries `{bank, col[8:3], col[2:0]+k}`. The low three bits wrap modulo 8 and `bank` sits in the top two bits.
- R5: For the two ticks before the first beat, `dqs_oe` is 1 and `dqs_out` is 0 (preamble).
- R6: While `dq_valid` is high, `dqs_oe` is high and `dqs_out` is 1 on even beats and 0 on odd beats.
- R7: On the tick after the last beat, `dq_valid`, `dqs_oe` and `dqs_out` are all 0.
- R8: A Precharge sampled at edge P to the same bank as a Read sampled at edge E, with 1 <= P-E <= 7, turns all three outputs off from edge P+L. Exactly P-E beats are delivered.
- R9: A Precharge to a different bank, or one sampled at P-E >= 8, leaves the burst unchanged.
- R10: While `rst_n` is low, `dq_valid`, `dqs_oe` and `dqs_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the memory clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cl_mode | input | 2 | CAS latency select, held stable between bursts |
| cmd | input | 2 | Decoded command code |
| bank | input | 2 | Bank address of the command |
| col | input | 9 | Start column of a Read |
| dq_valid | output | 1 | A data beat is on `dq_out` this tick |
| dq_out | output | 11 | Read data beat |
| dqs_oe | output | 1 | Strobe driver enabled |
| dqs_out | output | 1 | Strobe level |

## Verification
A wrong tap in the latency line moves the preamble and the first beat by whole ticks. The per-tick comparison catches this on the first affected tick of the burst. A stale in-flight state, such as the wrong bank, a wrong age, or an expired window still treated as live, changes how many beats are delivered, either from a wrong cut or from a missed cut. This appears L ticks after the Precharge and again in the per-case beat count. A beat counter or strobe phase that is off shows up at once in the data low bits or in the `dqs_out` level of the next beat.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'b00,
        CMD_READ = 2'b01,
        CMD_PRE  = 2'b10,
        CMD_RSV  = 2'b11
    } cmd_e;

    // Latency in half-clock ticks for each mode code
    function automatic logic [2:0] lat_ticks(input logic [1:0] mode);
        case (mode)
            2'd0:    lat_ticks = 3'd4;
            2'd1:    lat_ticks = 3'd5;
            default: lat_ticks = 3'd6;
        endcase
    endfunction

endpackage

// File: rtl/rd_cmd_track.sv
module rd_cmd_track #(
    parameter int BANK_W = 2,
    parameter int BURST  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd,
    input  logic [BANK_W-1:0] bank,
    output logic              rd_push,
    output logic              cut_push
);
    import ddr_rd_pkg::*;

    localparam int AGE_W = $clog2(BURST);

    typedef struct packed {
        logic              live;
        logic [BANK_W-1:0] bank;
        logic [AGE_W-1:0]  age;
    } trk_t;

    trk_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        rd_push  = (cmd == CMD_READ);
        cut_push = 1'b0;
        if (st_q.live) begin
            if (st_q.age == AGE_W'(BURST - 1)) st_d.live = 1'b0;
            else                               st_d.age  = st_q.age + 1'b1;
        end
        if (cmd == CMD_PRE && st_q.live && bank == st_q.bank &&
            st_q.age < AGE_W'(BURST - 1)) begin
            cut_push  = 1'b1;
            st_d.live = 1'b0;
        end
        if (rd_push) begin
            st_d.live = 1'b1;
            st_d.bank = bank;
            st_d.age  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    cut_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cut_push |=> !cut_push);

endmodule

// File: rtl/rd_lat_line.sv
module rd_lat_line #(
    parameter int PAY_W = 11,
    parameter int DEPTH = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(DEPTH+1)-1:0] lat,
    input  logic                       rd_in,
    input  logic                       cut_in,
    input  logic [PAY_W-1:0]           pay_in,
    output logic                       pre_tap,
    output logic                       start_tap,
    output logic                       cut_tap,
    output logic [PAY_W-1:0]           pay_tap
);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0]            rd;
        logic [DEPTH-1:0]            cut;
        logic [DEPTH-1:0][PAY_W-1:0] pay;
    } line_t;

    line_t st_q, st_d;
    logic [IDX_W-1:0] start_idx, pre_idx;

    always_comb begin
        st_d.rd     = {st_q.rd[DEPTH-2:0], rd_in};
        st_d.cut    = {st_q.cut[DEPTH-2:0], cut_in};
        st_d.pay[0] = pay_in;
        for (int i = 1; i < DEPTH; i++) st_d.pay[i] = st_q.pay[i-1];
        start_idx = IDX_W'(lat - 1'b1);
        pre_idx   = IDX_W'(lat - 2'd3);
        start_tap = st_q.rd[start_idx];
        cut_tap   = st_q.cut[start_idx];
        pay_tap   = st_q.pay[start_idx];
        pre_tap   = st_q.rd[pre_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/rd_burst_out.sv
module rd_burst_out #(
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int BURST  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pre_go,
    input  logic                    start_go,
    input  logic                    cut_go,
    input  logic [BANK_W+COL_W-1:0] start_pay,
    output logic                    dq_valid,
    output logic [BANK_W+COL_W-1:0] dq_out,
    output logic                    dqs_oe,
    output logic                    dqs_out
);
    localparam int BEAT_W = $clog2(BURST);
    localparam int DATA_W = BANK_W + COL_W;

    typedef struct packed {
        logic              busy;
        logic [BEAT_W-1:0] beat;
        logic [DATA_W-1:0] base;
        logic              oe;
        logic              dqs;
    } out_t;

    out_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.beat == BEAT_W'(BURST - 1)) begin
                st_d.busy = 1'b0;
                st_d.oe   = 1'b0;
                st_d.dqs  = 1'b0;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
                st_d.dqs  = ~st_q.dqs;
            end
        end
        if (pre_go) begin
            st_d.oe  = 1'b1;
            st_d.dqs = 1'b0;
        end
        if (start_go) begin
            st_d.busy = 1'b1;
            st_d.beat = '0;
            st_d.base = start_pay;
            st_d.oe   = 1'b1;
            st_d.dqs  = 1'b1;
        end
        if (cut_go) begin
            st_d.busy = 1'b0;
            st_d.oe   = 1'b0;
            st_d.dqs  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dq_valid = st_q.busy;
    assign dqs_oe   = st_q.oe;
    assign dqs_out  = st_q.dqs;
    assign dq_out   = {st_q.base[DATA_W-1:BEAT_W],
                       st_q.base[BEAT_W-1:0] + st_q.beat};

    // R6
    dqs_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid && $past(dq_valid) |-> dqs_out != $past(dqs_out));
    // R6
    oe_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid |-> dqs_oe);
    // R5
    preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_valid) |-> dqs_out && $past(dqs_oe) && !$past(dqs_out) && $past(dqs_oe, 2));
    // R4
    beat_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid && $past(dq_valid) |->
        dq_out[BEAT_W-1:0] == $past(dq_out[BEAT_W-1:0]) + 1'b1);
    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_valid) |-> !dqs_oe && !dqs_out);

endmodule

// File: rtl/ddr_rd_trunc.sv
module ddr_rd_trunc #(
    parameter int BANK_W  = 2,
    parameter int COL_W   = 9,
    parameter int BURST   = 8,
    parameter int LAT_MAX = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              cl_mode,
    input  logic [1:0]              cmd,
    input  logic [BANK_W-1:0]       bank,
    input  logic [COL_W-1:0]        col,
    output logic                    dq_valid,
    output logic [BANK_W+COL_W-1:0] dq_out,
    output logic                    dqs_oe,
    output logic                    dqs_out
);
    localparam int DATA_W = BANK_W + COL_W;
    localparam int LAT_W  = $clog2(LAT_MAX + 1);

    logic              rd_push, cut_push;
    logic              pre_tap, start_tap, cut_tap;
    logic [DATA_W-1:0] pay_tap;
    logic [LAT_W-1:0]  lat;

    assign lat = LAT_W'(ddr_rd_pkg::lat_ticks(cl_mode));

    rd_cmd_track #(.BANK_W(BANK_W), .BURST(BURST)) u_track (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank),
        .rd_push(rd_push), .cut_push(cut_push)
    );

    rd_lat_line #(.PAY_W(DATA_W), .DEPTH(LAT_MAX)) u_line (
        .clk(clk), .rst_n(rst_n), .lat(lat),
        .rd_in(rd_push), .cut_in(cut_push), .pay_in({bank, col}),
        .pre_tap(pre_tap), .start_tap(start_tap), .cut_tap(cut_tap),
        .pay_tap(pay_tap)
    );

    rd_burst_out #(.BANK_W(BANK_W), .COL_W(COL_W), .BURST(BURST)) u_out (
        .clk(clk), .rst_n(rst_n),
        .pre_go(pre_tap), .start_go(start_tap), .cut_go(cut_tap),
        .start_pay(pay_tap),
        .dq_valid(dq_valid), .dq_out(dq_out),
        .dqs_oe(dqs_oe), .dqs_out(dqs_out)
    );

endmodule

// File: tb/ddr_rd_trunc_tb.sv
module ddr_rd_trunc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cl_mode = 2'd0;
    logic [1:0]  cmd = 2'b00;
    logic [1:0]  bank = 2'd0;
    logic [8:0]  col = '0;
    logic        dq_valid, dqs_oe, dqs_out;
    logic [10:0] dq_out;

    int errors = 0, checks = 0;
    int edge_n = 0;
    int rd_e = -1000, cut_e = 1000000;
    logic [1:0] rd_bank = '0;
    logic [8:0] rd_col = '0;
    int beats_seen = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) edge_n <= edge_n + 1;

    ddr_rd_trunc u_dut (
        .clk(clk), .rst_n(rst_n), .cl_mode(cl_mode), .cmd(cmd),
        .bank(bank), .col(col), .dq_valid(dq_valid), .dq_out(dq_out),
        .dqs_oe(dqs_oe), .dqs_out(dqs_out)
    );

    // R2 mapping of mode code to ticks
    function automatic int lat_of(input logic [1:0] m);
        return (m == 2'd0) ? 4 : (m == 2'd1) ? 5 : 6;
    endfunction

    task automatic check_tick();
        int rel; bit cut_on, ev, eoe, edqs; logic [10:0] edat; bit bad;
        rel    = edge_n - (rd_e + lat_of(cl_mode));
        cut_on = edge_n >= cut_e + lat_of(cl_mode);
        ev     = rel >= 0 && rel < 8 && !cut_on;
        eoe    = ev || ((rel == -2 || rel == -1) && !cut_on);
        edqs   = ev && (rel % 2 == 0);
        edat   = {rd_bank, rd_col[8:3], 3'(rd_col[2:0] + 3'(rel))};
        if (dq_valid) beats_seen++;
        checks++;
        bad = 0;
        if (dq_valid !== ev) begin
            bad = 1;
            $display("FAIL R2/R3/R8 dq_valid tick %0d: got %0b exp %0b", edge_n, dq_valid, ev);
        end
        if (ev && dq_out !== edat) begin
            bad = 1;
            $display("FAIL R4 dq_out tick %0d: got %h exp %h", edge_n, dq_out, edat);
        end
        if (dqs_oe !== eoe) begin
            bad = 1;
            $display("FAIL R5/R7 dqs_oe tick %0d: got %0b exp %0b", edge_n, dqs_oe, eoe);
        end
        if (dqs_out !== edqs) begin
            bad = 1;
            $display("FAIL R6 dqs_out tick %0d: got %0b exp %0b", edge_n, dqs_out, edqs);
        end
        if (bad) errors++;
    endtask

    task automatic step(input logic [1:0] c, input logic [1:0] b, input logic [8:0] cl);
        @(negedge clk);
        check_tick();
        cmd = c; bank = b; col = cl;
        if (c == 2'b01) begin
            rd_e = edge_n + 1; cut_e = 1000000; rd_bank = b; rd_col = cl;
        end else if (c == 2'b10 && b == rd_bank &&
                     (edge_n + 1 - rd_e) >= 1 && (edge_n + 1 - rd_e) < 8) begin
            cut_e = edge_n + 1;
        end
    endtask

    // d: ticks from Read to Precharge; pb: precharge bank; use_pre: send it
    task automatic run_case(input logic [1:0] m, input int d, input logic [1:0] rb,
                            input logic [1:0] pb, input bit use_pre, input logic [8:0] c);
        int exp_beats;
        @(negedge clk);
        check_tick();
        cl_mode = m;
        beats_seen = 0;
        step(2'b01, rb, c);
        for (int i = 1; i < d; i++) step((i == 1) ? 2'b11 : 2'b00, pb, 9'h1ff); // R1 reserved code
        step(use_pre ? 2'b10 : 2'b00, pb, 9'h000);
        for (int i = 0; i < 24; i++) step(2'b00, 2'd0, 9'h000);
        exp_beats = (use_pre && pb == rb && d < 8) ? d : 8;
        checks++;
        if (beats_seen != exp_beats) begin
            errors++;
            $display("FAIL R3/R8/R9 beat count mode %0d d %0d: got %0d exp %0d",
                     m, d, beats_seen, exp_beats);
        end
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (dq_valid !== 1'b0 || dqs_oe !== 1'b0 || dqs_out !== 1'b0) begin
                errors++;
                $display("FAIL R10 reset outputs: got %0b%0b%0b exp 000", dq_valid, dqs_oe, dqs_out);
            end
        end
        rst_n = 1'b1;
        for (int m = 0; m < 4; m++) begin
            run_case(2'(m), 3, 2'd1, 2'd1, 1'b0, 9'(m * 37 + 6));          // R3 plain
            for (int d = 1; d <= 9; d++)                                       // R8, R9 at d>=8
                run_case(2'(m), d, 2'(d), 2'(d), 1'b1, 9'(d * 53 + m * 11));
            run_case(2'(m), 2, 2'd2, 2'd3, 1'b1, 9'h0fe);                      // R9 other bank
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule